// File: doc/BRIEF.md
# Bimodal Effective Address Generator

This block forms the effective address of a storage request. It adds a base value, an index value and a 12-bit unsigned displacement. It then limits the sum to 24 or 31 bits, depending on the addressing-mode bit taken from the current status word. Each request is tagged with an access class. Instruction fetches and operand accesses follow the mode. Accesses to system tables and to the event monitor always keep the full 31-bit result, whatever the mode.

A selector of zero for the base or the index means a zero term, and the value on the matching data input is then ignored. The sum is registered. It appears one cycle after the request on a 32-bit result bus, together with a valid flag. The mode and the class are sampled together with the request, so a later change of mode never alters a result that is already in the pipeline.

Top module: `eag_top`

## Requirements
- R1: The mode input `amode` selects the address width for instruction (class code 0) and operand (class code 1) requests: 0 selects 24-bit and 1 selects 31-bit.
- R2: In 31-bit mode the result is base term + index term + displacement, taken modulo 2^31, so a carry out of bit 30 is dropped.
- R3: In 24-bit mode, for class codes 0 and 1, the result is the same sum reduced modulo 2^24, and result bits 30..24 read as zero.
- R4: Table requests (class code 2) and monitor requests (class code 3) always produce the full 31-bit sum, whatever the value of `amode`.
- R5: When `base_sel` is zero the base term is zero and `base_val` is ignored. When `idx_sel` is zero the index term is zero and `idx_val` is ignored.
- R6: A request accepted on a clock edge sets `ea_valid` high for exactly the following cycle. When `req_valid` is low, `ea_valid` falls on the next edge and `ea_addr` keeps its previous value.
- R7: `amode` and `req_class` are sampled on the edge that accepts the request. Changing them afterwards does not change that request's result.
- R8: Bit 31 of `ea_addr` always reads zero.
- R9: While `rst` is high, on each clock edge `ea_valid` and `ea_addr` are cleared to zero.
- R10: The displacement is unsigned: a value of 0xFFF adds 4095 and is never sign-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_class | input | 2 | Access class: 0 instruction, 1 operand, 2 table, 3 monitor |
| amode | input | 1 | Addressing-mode bit from the status word (0 = 24-bit, 1 = 31-bit) |
| base_sel | input | 4 | Base register selector; zero means no base |
| base_val | input | 31 | Base register contents |
| idx_sel | input | 4 | Index register selector; zero means no index |
| idx_val | input | 31 | Index register contents |
| disp | input | 12 | Unsigned displacement |
| ea_valid | output | 1 | Result valid, one cycle after the request |
| ea_addr | output | 32 | Effective address; bit 31 is always zero |

## Verification
The hardest case to reach from the ports is a request whose mode is flipped in the very next cycle. The stimulus issues 24-bit and 31-bit requests back to back and toggles `amode` and `req_class` while the earlier result is still in the register. Both results must still match the values formed at acceptance. Carries that leave bit 23 or bit 30 are produced with base, index and displacement values chosen so that only the wrap rule separates the right answer from the wrong one. Table and monitor requests reuse the same operands under 24-bit mode, which shows the bypass.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int ADDR_W   = 31;
    localparam int NARROW_W = 24;
    localparam int DISP_W   = 12;
    localparam int SEL_W    = 4;
    localparam int BUS_W    = ADDR_W + 1;

    typedef enum logic [1:0] {
        CLS_INSN  = 2'd0,
        CLS_OPND  = 2'd1,
        CLS_TABLE = 2'd2,
        CLS_MON   = 2'd3
    } acc_class_e;

    typedef struct packed {
        acc_class_e        cls;
        logic              amode;
        logic [ADDR_W-1:0] base_term;
        logic [ADDR_W-1:0] idx_term;
        logic [DISP_W-1:0] disp;
    } eag_req_t;

    function automatic logic keeps_full_width(acc_class_e cls, logic amode);
        return amode || (cls == CLS_TABLE) || (cls == CLS_MON);
    endfunction

endpackage

// File: rtl/eag_term_gate.sv
module eag_term_gate #(
    parameter int SEL_W  = 4,
    parameter int DATA_W = 31
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] val,
    output logic [DATA_W-1:0] term
);
    always_comb begin
        term = (sel == '0) ? '0 : val;
    end
endmodule

// File: rtl/eag_adder.sv
module eag_adder #(
    parameter int ADDR_W = 31,
    parameter int DISP_W = 12
) (
    input  logic [ADDR_W-1:0] a,
    input  logic [ADDR_W-1:0] b,
    input  logic [DISP_W-1:0] d,
    output logic [ADDR_W-1:0] sum
);
    localparam int PAD_W = ADDR_W - DISP_W;

    always_comb begin
        sum = a + b + {{PAD_W{1'b0}}, d};
    end
endmodule

// File: rtl/eag_width_limit.sv
module eag_width_limit
    import eag_pkg::*;
#(
    parameter int FULL_W   = 31,
    parameter int NARROW_W = 24
) (
    input  logic [FULL_W-1:0] sum,
    input  acc_class_e        cls,
    input  logic              amode,
    output logic [FULL_W-1:0] addr
);
    localparam int ZPAD_W = FULL_W - NARROW_W;

    always_comb begin
        if (keeps_full_width(cls, amode)) begin
            addr = sum;
        end else begin
            addr = {{ZPAD_W{1'b0}}, sum[NARROW_W-1:0]};
        end
    end
endmodule

// File: rtl/eag_top.sv
module eag_top
    import eag_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [1:0]          req_class,
    input  logic                amode,
    input  logic [SEL_W-1:0]    base_sel,
    input  logic [ADDR_W-1:0]   base_val,
    input  logic [SEL_W-1:0]    idx_sel,
    input  logic [ADDR_W-1:0]   idx_val,
    input  logic [DISP_W-1:0]   disp,
    output logic                ea_valid,
    output logic [BUS_W-1:0]    ea_addr
);
    localparam int NTERM = 2;

    logic [NTERM-1:0][SEL_W-1:0]  sel_arr;
    logic [NTERM-1:0][ADDR_W-1:0] val_arr;
    logic [NTERM-1:0][ADDR_W-1:0] term_arr;

    assign sel_arr = {idx_sel, base_sel};
    assign val_arr = {idx_val, base_val};

    for (genvar g = 0; g < NTERM; g++) begin : g_term
        eag_term_gate #(.SEL_W(SEL_W), .DATA_W(ADDR_W)) u_gate (
            .sel  (sel_arr[g]),
            .val  (val_arr[g]),
            .term (term_arr[g])
        );
    end

    eag_req_t req;
    always_comb begin
        req.cls       = acc_class_e'(req_class);
        req.amode     = amode;
        req.base_term = term_arr[0];
        req.idx_term  = term_arr[1];
        req.disp      = disp;
    end

    logic [ADDR_W-1:0] raw_sum;
    logic [ADDR_W-1:0] lim_addr;

    eag_adder #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_add (
        .a   (req.base_term),
        .b   (req.idx_term),
        .d   (req.disp),
        .sum (raw_sum)
    );

    eag_width_limit #(.FULL_W(ADDR_W), .NARROW_W(NARROW_W)) u_lim (
        .sum   (raw_sum),
        .cls   (req.cls),
        .amode (req.amode),
        .addr  (lim_addr)
    );

    logic              vld_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            vld_q <= req_valid;
            if (req_valid) begin
                addr_q <= lim_addr;
            end
        end
    end

    assign ea_valid = vld_q;
    assign ea_addr  = {1'b0, addr_q};
endmodule

// File: rtl/eag_checker.sv
module eag_checker
    import eag_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_class,
    input logic              amode,
    input logic [SEL_W-1:0]  base_sel,
    input logic [SEL_W-1:0]  idx_sel,
    input logic [DISP_W-1:0] disp,
    input logic              ea_valid,
    input logic [BUS_W-1:0]  ea_addr
);
    localparam int DZ_W = BUS_W - DISP_W;

    assert_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> ea_valid);

    assert_idle_drops_R6: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!ea_valid && $stable(ea_addr)));

    assert_narrow_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !amode && !req_class[1]) |=> (ea_addr[30:24] == '0));

    assert_zero_selectors_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && base_sel == '0 && idx_sel == '0)
            |=> (ea_addr == {{DZ_W{1'b0}}, $past(disp)}));

    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> (!ea_valid && ea_addr == '0));
endmodule

bind eag_top eag_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_class (req_class),
    .amode     (amode),
    .base_sel  (base_sel),
    .idx_sel   (idx_sel),
    .disp      (disp),
    .ea_valid  (ea_valid),
    .ea_addr   (ea_addr)
);

// File: tb/tb_eag_top.sv
module tb_eag_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_class = 2'd0;
    logic        amode = 1'b0;
    logic [3:0]  base_sel = 4'd0;
    logic [30:0] base_val = '0;
    logic [3:0]  idx_sel = 4'd0;
    logic [30:0] idx_val = '0;
    logic [11:0] disp = '0;
    logic        ea_valid;
    logic [31:0] ea_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [31:0] addr;
        string       tag;
    } exp_t;
    exp_t expq[$];

    always #4 clk = ~clk;

    eag_top dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_class(req_class),
        .amode(amode), .base_sel(base_sel), .base_val(base_val),
        .idx_sel(idx_sel), .idx_val(idx_val), .disp(disp),
        .ea_valid(ea_valid), .ea_addr(ea_addr)
    );

    function automatic logic [31:0] model(input logic [1:0] c, input logic m,
                                          input logic [3:0] bs, input logic [30:0] bv,
                                          input logic [3:0] xs, input logic [30:0] xv,
                                          input logic [11:0] d);
        logic [63:0] s;
        s = 64'(d);
        if (bs != 0) s = s + 64'(bv);
        if (xs != 0) s = s + 64'(xv);
        s = s % 64'h8000_0000;
        if (!m && c < 2) s = s % 64'h0100_0000;
        return s[31:0];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: presents one request for one cycle and pushes its expected result.
    task automatic send(input string tag, input logic [1:0] c, input logic m,
                        input logic [3:0] bs, input logic [30:0] bv,
                        input logic [3:0] xs, input logic [30:0] xv,
                        input logic [11:0] d);
        exp_t e;
        req_valid = 1'b1; req_class = c; amode = m;
        base_sel = bs; base_val = bv; idx_sel = xs; idx_val = xv; disp = d;
        e.addr = model(c, m, bs, bv, xs, xv, d);
        e.tag  = tag;
        expq.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: samples shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst && ea_valid) begin
                if (expq.size() == 0) begin
                    n_checks++; n_fail++;
                    $display("FAIL R6 actual=unexpected valid expected=no valid");
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(e.tag, ea_addr, e.addr);
                    check("R8", {31'b0, ea_addr[31]}, 32'd0);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9", {31'b0, ea_valid}, 32'd0);
        check("R9", ea_addr, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R2: wrap at 2^31 and ordinary sum in 31-bit mode
        send("R2", 2'd0, 1'b1, 4'd1, 31'h7FFF_FFFF, 4'd2, 31'h1, 12'h000);
        send("R2", 2'd1, 1'b1, 4'd3, 31'h1234_5678, 4'd4, 31'h100, 12'hFFF);
        // R1: same operands, mode selects width
        send("R1", 2'd0, 1'b1, 4'd5, 31'h7ABC_DEF0, 4'd0, 31'h0, 12'h010);
        send("R1", 2'd0, 1'b0, 4'd5, 31'h7ABC_DEF0, 4'd0, 31'h0, 12'h010);
        // R3: wrap at 2^24 in 24-bit mode
        send("R3", 2'd1, 1'b0, 4'd1, 31'h00FF_FFFF, 4'd0, 31'h0, 12'h001);
        send("R3", 2'd1, 1'b0, 4'd1, 31'h00FF_F000, 4'd2, 31'h0000_0F00, 12'h200);
        idle(2);
        // R4: table and monitor classes stay 31-bit under 24-bit mode
        send("R4", 2'd2, 1'b0, 4'd1, 31'h7ABC_DEF0, 4'd2, 31'h0100_0000, 12'h0AB);
        send("R4", 2'd3, 1'b0, 4'd1, 31'h4000_0000, 4'd0, 31'h0, 12'h004);
        send("R4", 2'd2, 1'b0, 4'd1, 31'h00FF_FFFF, 4'd0, 31'h0, 12'h001);
        // R5: zero selectors ignore data inputs
        send("R5", 2'd0, 1'b1, 4'd0, 31'h7FFF_0000, 4'd0, 31'h5555_5555, 12'h123);
        send("R5", 2'd2, 1'b1, 4'd0, 31'h1111_1111, 4'd7, 31'h0000_1000, 12'h001);
        send("R5", 2'd1, 1'b1, 4'd9, 31'h0000_2000, 4'd0, 31'h7777_7777, 12'h000);
        // R10: displacement is unsigned
        send("R10", 2'd0, 1'b1, 4'd0, 31'h0, 4'd0, 31'h0, 12'hFFF);
        send("R10", 2'd1, 1'b0, 4'd1, 31'h0000_1000, 4'd0, 31'h0, 12'h800);
        idle(1);
        // R7: mode flips every cycle; results keep the mode seen at acceptance
        send("R7", 2'd0, 1'b0, 4'd1, 31'h7F00_0001, 4'd0, 31'h0, 12'h000);
        send("R7", 2'd0, 1'b1, 4'd1, 31'h7F00_0001, 4'd0, 31'h0, 12'h000);
        send("R7", 2'd1, 1'b0, 4'd1, 31'h7F00_0001, 4'd0, 31'h0, 12'h000);
        req_valid = 1'b0; amode = 1'b1; req_class = 2'd2;
        @(negedge clk);
        send("R7", 2'd0, 1'b1, 4'd1, 31'h7F00_0001, 4'd0, 31'h0, 12'h000);
        req_valid = 1'b0; amode = 1'b0;
        @(negedge clk);
        // R6: hold while idle, no stray valid
        idle(4);
        check("R6", ea_addr, model(2'd0, 1'b1, 4'd1, 31'h7F00_0001, 4'd0, 31'h0, 12'h000));
        check("R6", {31'b0, ea_valid}, 32'd0);
        check("R6", 32'(expq.size()), 32'd0);
        // R9: reset clears state after activity
        rst = 1'b1;
        @(negedge clk);
        check("R9", {31'b0, ea_valid}, 32'd0);
        check("R9", ea_addr, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule